// File: doc/BRIEF.md
# Serial Bus Master Event and Interrupt Register Unit

This unit collects the single-cycle event pulses produced by a serial bus master (missing acknowledge, lost arbitration, access complete, and the four receive/transmit ready and draining events) into sticky status bits. Software sees them through two 16-bit read views. The raw view shows every latched event plus a live bus-busy level. The masked view shows only the events that are currently enabled.

Software acknowledges an event by writing a one to its bit in either status view. The enable mask has no plain write port. It is changed through two separate addresses: one sets the bits written as one, the other clears them. This lets software change single enables without a read-modify-write. One registered interrupt line is raised while any enabled event is pending.

Event bit positions are 0 no-acknowledge, 1 arbitration lost, 2 access ready, 3 receive ready, 4 transmit ready, 5 receive draining, 6 transmit draining. The bus-busy level sits at bit 12 of the raw view. Word addresses are 0 raw status, 1 masked status, 2 enable-set, 3 enable-clear.

Top module: `sbm_evt_irq`

## Requirements
- R1: After reset all status bits, all enable bits, the interrupt output and the read data are 0.
- R2: An event pulse on `evt_pulse[i]` sets status bit i at the next clock edge, and the bit stays set until software clears it.
- R3: A write to address 0 or 1 clears every status bit written as 1. Bits written as 0 are unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to address 2 sets every enable bit written as 1, and 0 bits have no effect. A read of address 2 or of address 3 returns the current enable mask in bits 6..0.
- R6: A write to address 3 clears every enable bit written as 1, so writing 0xFFFF disables all events.
- R7: A read of address 1 returns status AND enable. A read of address 0 returns all status bits whatever the mask.
- R8: Bit 12 of the raw view is the live `bus_busy` level. It is independent of the mask and is always 0 in the masked view.
- R9: `irq` equals the OR of (status AND enable) as it stood one clock earlier.
- R10: `reg_rdata` is loaded at the clock edge on which `reg_rd` is high and holds otherwise. Addresses 4 to 7 read as 0, and writes to them have no effect. Write bits 15..7 never change status or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| evt_pulse | input | 7 | Single-cycle event pulses, one per event bit |
| bus_busy | input | 1 | Live bus-busy level |
| irq | output | 1 | Interrupt request |

## Verification
A pulse or clearing write is visible in the status one edge after it is driven, and in `irq` one edge later still. A read captures the state present before its own edge and presents it after that edge. The bench drives every stimulus on a falling edge and samples on the next falling edge. For `irq` it checks both the cycle in which the old value must still hold and the following cycle in which the new value is due, so an off-by-one latency is reported. Mask changes are checked the same way: the interrupt rises or falls exactly one cycle after the mask write lands.

// File: rtl/sbm_evt_pkg.sv
`timescale 1ns/1ps
package sbm_evt_pkg;
  // Word addresses of the register views
  localparam int unsigned ADR_RAW  = 0;
  localparam int unsigned ADR_MSK  = 1;
  localparam int unsigned ADR_ESET = 2;
  localparam int unsigned ADR_ECLR = 3;

  // Event bit positions
  localparam int unsigned EV_NOACK   = 0;
  localparam int unsigned EV_ARBLOST = 1;
  localparam int unsigned EV_ACCRDY  = 2;
  localparam int unsigned EV_RXRDY   = 3;
  localparam int unsigned EV_TXRDY   = 4;
  localparam int unsigned EV_RXDRAIN = 5;
  localparam int unsigned EV_TXDRAIN = 6;
  localparam int unsigned EV_COUNT   = 7;
endpackage

// File: rtl/sbm_evt_status.sv
`timescale 1ns/1ps
// Sticky event bits: set by pulse, cleared by write-one, set has priority.
module sbm_evt_status #(
  parameter int unsigned NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_vec,
  input  logic [NUM_EVT-1:0] clr_vec,
  output logic [NUM_EVT-1:0] sts_q
);
  logic [NUM_EVT-1:0] sts_d;
  logic [NUM_EVT-1:0] sts_ce;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_comb begin
      sts_ce[i] = set_vec[i] | clr_vec[i];
      sts_d[i]  = set_vec[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q[i] <= 1'b0;
      end else if (sts_ce[i]) begin
        sts_q[i] <= sts_d[i];
      end
    end
  end
endmodule

// File: rtl/sbm_evt_mask.sv
`timescale 1ns/1ps
// Enable mask with separate set and clear write ports.
module sbm_evt_mask #(
  parameter int unsigned NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_vec,
  input  logic [NUM_EVT-1:0] clr_vec,
  output logic [NUM_EVT-1:0] en_q
);
  logic [NUM_EVT-1:0] en_d;
  logic               en_ce;

  always_comb begin
    en_ce = |(set_vec | clr_vec);
    en_d  = (en_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/sbm_evt_rdport.sv
`timescale 1ns/1ps
// Registered read multiplexer for the status and enable views.
module sbm_evt_rdport
  import sbm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_EVT  = 7,
  parameter int unsigned BUSY_BIT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_EVT-1:0] sts,
  input  logic [NUM_EVT-1:0] en,
  input  logic               busy,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [DATA_W-1:0] raw_w;
  logic [DATA_W-1:0] msk_w;
  logic [DATA_W-1:0] ena_w;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    raw_w = '0;
    msk_w = '0;
    ena_w = '0;
    raw_w[NUM_EVT-1:0] = sts;
    raw_w[BUSY_BIT]    = busy;
    msk_w[NUM_EVT-1:0] = sts & en;
    ena_w[NUM_EVT-1:0] = en;
  end

  always_comb begin
    case (addr)
      ADDR_W'(ADR_RAW):  rdata_d = raw_w;
      ADDR_W'(ADR_MSK):  rdata_d = msk_w;
      ADDR_W'(ADR_ESET): rdata_d = ena_w;
      ADDR_W'(ADR_ECLR): rdata_d = ena_w;
      default:           rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/sbm_evt_irq.sv
`timescale 1ns/1ps
module sbm_evt_irq
  import sbm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_EVT  = EV_COUNT,
  parameter int unsigned BUSY_BIT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               bus_busy,
  output logic               irq
);
  logic [NUM_EVT-1:0] wlo;
  logic               hit_sts;
  logic               hit_eset;
  logic               hit_eclr;
  logic [NUM_EVT-1:0] sts_clr;
  logic [NUM_EVT-1:0] en_set;
  logic [NUM_EVT-1:0] en_clr;
  logic [NUM_EVT-1:0] sts_q;
  logic [NUM_EVT-1:0] en_q;
  logic               irq_d;
  logic               irq_q;
  logic               unused_hi;

  // Write decode
  always_comb begin
    wlo      = reg_wdata[NUM_EVT-1:0];
    hit_sts  = reg_wr && ((reg_addr == ADDR_W'(ADR_RAW)) || (reg_addr == ADDR_W'(ADR_MSK)));
    hit_eset = reg_wr && (reg_addr == ADDR_W'(ADR_ESET));
    hit_eclr = reg_wr && (reg_addr == ADDR_W'(ADR_ECLR));
    sts_clr  = hit_sts  ? wlo : '0;
    en_set   = hit_eset ? wlo : '0;
    en_clr   = hit_eclr ? wlo : '0;
  end
  assign unused_hi = ^reg_wdata[DATA_W-1:NUM_EVT];

  sbm_evt_status #(.NUM_EVT(NUM_EVT)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_pulse), .clr_vec(sts_clr), .sts_q(sts_q)
  );

  sbm_evt_mask #(.NUM_EVT(NUM_EVT)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_vec(en_set), .clr_vec(en_clr), .en_q(en_q)
  );

  sbm_evt_rdport #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .BUSY_BIT(BUSY_BIT)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr), .sts(sts_q),
    .en(en_q), .busy(bus_busy), .rdata_q(reg_rdata)
  );

  // Interrupt: registered OR of enabled pending events
  always_comb begin
    irq_d = |(sts_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/sbm_evt_irq_chk.sv
`timescale 1ns/1ps
module sbm_evt_irq_chk
  import sbm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned NUM_EVT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [NUM_EVT-1:0] wlo,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic [NUM_EVT-1:0] sts,
  input logic [NUM_EVT-1:0] mask,
  input logic               irq
);
  logic [NUM_EVT-1:0] c_sclr;
  logic [NUM_EVT-1:0] c_eset;
  logic [NUM_EVT-1:0] c_eclr;

  always_comb begin
    c_sclr = (reg_wr && (reg_addr == ADDR_W'(ADR_RAW) || reg_addr == ADDR_W'(ADR_MSK))) ? wlo : '0;
    c_eset = (reg_wr && reg_addr == ADDR_W'(ADR_ESET)) ? wlo : '0;
    c_eclr = (reg_wr && reg_addr == ADDR_W'(ADR_ECLR)) ? wlo : '0;
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|$past(sts & mask))); // R9

  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_pulse |=> ((sts & $past(evt_pulse)) == $past(evt_pulse))); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sts) & ~$past(c_sclr)) & ~sts) == '0)); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts) & ~$past(evt_pulse)) == '0)); // R2

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    |c_eset |=> ((mask & $past(c_eset)) == $past(c_eset))); // R5

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    |c_eclr |=> ((mask & $past(c_eclr)) == '0)); // R6

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_eset == '0 && c_eclr == '0) |=> $stable(mask)); // R10
endmodule

bind sbm_evt_irq sbm_evt_irq_chk #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wlo(reg_wdata[NUM_EVT-1:0]), .evt_pulse(evt_pulse), .sts(sts_q),
  .mask(en_q), .irq(irq)
);

// File: tb/sim_sbm_evt_irq.sv
`timescale 1ns/1ps
module sim_sbm_evt_irq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [6:0]  evt_pulse;
  logic        bus_busy;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] d;

  always #2.5 clk = ~clk;

  sbm_evt_irq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .bus_busy(bus_busy), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", reg_rdata, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d);
      chk("R1 view", d, 16'h0);
    end
  endtask

  task automatic t_sticky;
    pulse(7'h01);
    rd(3'd0, d); chk("R2 set", d, 16'h0001);
    @(negedge clk); @(negedge clk);
    rd(3'd0, d); chk("R2 hold", d, 16'h0001);
    rd(3'd1, d); chk("R7 masked none", d, 16'h0000);
    chk("R9 no irq disabled", {15'd0, irq}, 16'h0);
    wr(3'd0, 16'h0001);
  endtask

  task automatic t_w1c;
    pulse(7'h28);
    rd(3'd0, d); chk("R2 two bits", d, 16'h0028);
    wr(3'd0, 16'h0008);
    rd(3'd0, d); chk("R3 raw clr", d, 16'h0020);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R3 zero no effect", d, 16'h0020);
    wr(3'd1, 16'h0020);
    rd(3'd0, d); chk("R3 masked clr", d, 16'h0000);
  endtask

  task automatic t_collide;
    evt_pulse = 7'h04; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0004;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(3'd0, d); chk("R4 set wins", d, 16'h0004);
    wr(3'd0, 16'h0004);
  endtask

  task automatic t_mask;
    wr(3'd2, 16'h0012);
    rd(3'd2, d); chk("R5 set read", d, 16'h0012);
    rd(3'd3, d); chk("R5 clr addr read", d, 16'h0012);
    wr(3'd2, 16'h0000);
    rd(3'd2, d); chk("R5 zero no effect", d, 16'h0012);
    wr(3'd3, 16'h0002);
    rd(3'd2, d); chk("R6 clr bit", d, 16'h0010);
    wr(3'd2, 16'h0041);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, d); chk("R6 clr all", d, 16'h0000);
  endtask

  task automatic t_irq;
    wr(3'd2, 16'h0010);
    pulse(7'h10);
    chk("R9 not yet", {15'd0, irq}, 16'h0);
    @(negedge clk);
    chk("R9 raised", {15'd0, irq}, 16'h1);
    pulse(7'h01);
    rd(3'd1, d); chk("R7 masked", d, 16'h0010);
    rd(3'd0, d); chk("R7 raw all", d, 16'h0011);
    wr(3'd1, 16'h0010);
    chk("R9 still high", {15'd0, irq}, 16'h1);
    @(negedge clk);
    chk("R9 dropped", {15'd0, irq}, 16'h0);
    wr(3'd2, 16'h0001);
    chk("R9 mask not yet", {15'd0, irq}, 16'h0);
    @(negedge clk);
    chk("R9 mask raise", {15'd0, irq}, 16'h1);
    wr(3'd3, 16'hFFFF);
    @(negedge clk);
    chk("R9 mask drop", {15'd0, irq}, 16'h0);
    wr(3'd0, 16'h00FF);
  endtask

  task automatic t_busy;
    bus_busy = 1'b1;
    wr(3'd2, 16'h007F);
    rd(3'd0, d); chk("R8 raw busy", d, 16'h1000);
    rd(3'd1, d); chk("R8 masked no busy", d, 16'h0000);
    bus_busy = 1'b0;
    rd(3'd0, d); chk("R8 live drop", d, 16'h0000);
    chk("R9 busy no irq", {15'd0, irq}, 16'h0);
    wr(3'd3, 16'hFFFF);
  endtask

  task automatic t_misc;
    pulse(7'h02);
    wr(3'd5, 16'hFFFF);
    rd(3'd0, d); chk("R10 unused wr", d, 16'h0002);
    rd(3'd5, d); chk("R10 unused rd", d, 16'h0000);
    wr(3'd2, 16'hFF80);
    rd(3'd2, d); chk("R10 high bits", d, 16'h0000);
    rd(3'd0, d); chk("R10 pre hold", d, 16'h0002);
    pulse(7'h40);
    @(negedge clk);
    chk("R10 hold", reg_rdata, 16'h0002);
    rd(3'd0, d); chk("R10 reload", d, 16'h0042);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, d); chk("R3 clear all", d, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; evt_pulse = '0; bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_w1c();
    t_collide();
    t_mask();
    t_irq();
    t_busy();
    t_misc();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule